// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block collects a vector of interrupt request lines, tracks which of them are pending, and presents the pending source with the best priority to software through a small register port. Each source has its own control byte. That byte enables the source, chooses how the source triggers (active-high level, rising edge, falling edge, or both edges), and picks where the source is routed. The two routes that drive an output are the normal request line and the fast request line. A source routed anywhere else is tracked but drives neither output.

Raw inputs pass through a two-stage synchroniser before the block detects edges. An edge event is latched in a status bit and stays there until software writes a one to that bit. A level source's status bit simply follows its synchronised input while the source is enabled. Each output has a priority register. Its low six bits give the number of the best pending source on that route. With nothing pending they read 63, so software reads status bit 31 of the upper status word to tell whether source 63 is really pending. Bit 6 of each priority register chooses between fixed priority, where the lowest number wins, and rotating priority, where the search starts just after the source that was last acknowledged.

Top module: `intc_rotpri`

## Requirements
- R1: After a synchronous reset, every control byte reads 0: the source is disabled and routed to the normal request line. Both status words read 0, both outputs are low, and both priority registers read 0x3F (rotation off, index 63).
- R2: The control byte for source n sits at byte address 0x40+n and reads back as written. Bit 3 is the enable. Bit 5 selects rising edge and bit 6 selects falling edge; with both clear the source is active-high level. Bits 2:0 hold the route: 0 is the normal line, 1 is the fast line, and 2 to 7 drive neither output.
- R3: For an enabled level source, the status bit equals the synchronised input. It is 0 while the source is disabled. Writing a one to it has no effect.
- R4: A rising edge on an enabled rising-mode source sets its status bit, and the bit stays set after the input falls. Status word 0x80 holds sources 0-31 and word 0x84 holds sources 32-63, with source n at bit n mod 32. Writing a one to that bit clears the bit.
- R5: A falling edge on an enabled falling-mode source sets its status bit, and a rising edge on it does not.
- R6: Clearing the enable bit hides a source from both outputs and from both priority registers. An edge status bit that is already latched stays set.
- R7: The normal request output is high when any enabled source routed to the normal line has its status bit set. The fast request output follows the same rule for sources routed to the fast line.
- R8: Under fixed priority, the priority register at 0x20 (normal line) or 0x24 (fast line) returns the lowest-numbered pending enabled source on that route in bits 5:0, and returns 63 when none is pending. Status bit 31 at 0x84 tells a real source 63 from the idle value.
- R9: Writing a one to the status bit of the source currently reported for a route acknowledges that source. When bit 6 of that route's priority register is set, the search then starts at the next higher source number and wraps around after 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 64 | Asynchronous interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is valid the next cycle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data (control bytes use bits 7:0) |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal request output (registered) |
| fiq_o | output | 1 | Fast request output (registered) |

## Verification
The assertions assume that the bus never strobes read and write in the same cycle, that addresses are aligned for the word registers, and that every source is quiet or stable during reset. The bench drives every input on the falling clock edge, issues one bus access at a time, and waits several cycles after each source change before it samples anything. Rotation is checked only after the bench has set the acknowledge pointer explicitly, so the expected order of winners is known in advance.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int CTL_EN_BIT   = 3;
  localparam int CTL_RISE_BIT = 5;
  localparam int CTL_FALL_BIT = 6;
  localparam int PRI_ROT_BIT  = 6;
  localparam logic [2:0] ROUTE_NORM = 3'd0;
  localparam logic [2:0] ROUTE_FAST = 3'd1;
  localparam logic [7:0] ADR_PRI_NORM = 8'h20;
  localparam logic [7:0] ADR_PRI_FAST = 8'h24;
  localparam logic [7:0] ADR_STAT_LO  = 8'h80;
  localparam logic [7:0] ADR_STAT_HI  = 8'h84;
  localparam logic [1:0] CTL_REGION   = 2'b01;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_in,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       clr,
  output logic [7:0] ctl_q,
  output logic       stat_q,
  output logic       req_norm,
  output logic       req_fast
);
  logic s1, s2, s2_d;
  logic en, rise_m, fall_m, edge_m, edge_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; s2_d <= 1'b0;
    end else begin
      s1 <= raw_in; s2 <= s1; s2_d <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata;
  end

  assign en       = ctl_q[CTL_EN_BIT];
  assign rise_m   = ctl_q[CTL_RISE_BIT];
  assign fall_m   = ctl_q[CTL_FALL_BIT];
  assign edge_m   = rise_m | fall_m;
  assign edge_hit = en & ((rise_m & s2 & ~s2_d) | (fall_m & ~s2 & s2_d));

  always_ff @(posedge clk) begin
    if (rst)          stat_q <= 1'b0;
    else if (!edge_m) stat_q <= s2 & en;
    else              stat_q <= edge_hit | (stat_q & ~clr);
  end

  assign req_norm = stat_q & en & (ctl_q[2:0] == ROUTE_NORM);
  assign req_fast = stat_q & en & (ctl_q[2:0] == ROUTE_FAST);

  p_edge_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (edge_m && stat_q && !clr && !ctl_we) |=> stat_q);
  p_level_follow_r3: assert property (@(posedge clk) disable iff (rst)
    (!edge_m && en && !ctl_we) |=> (stat_q == $past(s2)));
  p_hidden_r6: assert property (@(posedge clk) disable iff (rst)
    (!en || ctl_q[2:1] != 2'b00) |-> (!req_norm && !req_fast));
endmodule

// File: rtl/intc_pick.sv
module intc_pick #(
  parameter int N     = 64,
  localparam int IW   = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic          rotate,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] win
);
  logic [IW-1:0] start;
  assign start = rotate ? IW'(last + 1'b1) : '0;

  always_comb begin
    any = 1'b0;
    win = '1;
    for (int i = 0; i < N; i++) begin
      if (!any && req[IW'(start + IW'(i))]) begin
        any = 1'b1;
        win = IW'(start + IW'(i));
      end
    end
  end

  p_win_pending_r8: assert property (@(posedge clk) disable iff (rst)
    any |-> req[win]);
  p_idle_63_r8: assert property (@(posedge clk) disable iff (rst)
    !any |-> (win == IW'(N - 1)));
  p_fixed_lowest_r8: assert property (@(posedge clk) disable iff (rst)
    (any && !rotate) |-> ((req & ((N'(1) << win) - N'(1))) == '0));
endmodule

// File: rtl/intc_rotpri.sv
module intc_rotpri
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  localparam int IW     = $clog2(NUM_SRC),
  localparam int NWORD  = NUM_SRC / 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [7:0]         ctl [NUM_SRC];
  logic [NUM_SRC-1:0] stat, req_n, req_f, clr_vec;
  logic               ctl_sel;
  logic               rot_n, rot_f;
  logic [IW-1:0]      last_n, last_f, win_n, win_f;
  logic               any_n, any_f, ack_n, ack_f;

  assign ctl_sel = bus_addr[7:6] == CTL_REGION;

  always_comb begin
    clr_vec = '0;
    if (bus_wr) begin
      if (bus_addr == ADR_STAT_LO) clr_vec[31:0] = bus_wdata;
      if (bus_addr == ADR_STAT_HI) clr_vec[NUM_SRC-1:32] = bus_wdata[NUM_SRC-33:0];
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    intc_src_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .raw_in   (src_in[g]),
      .ctl_we   (bus_wr && ctl_sel && bus_addr[5:0] == 6'(g)),
      .ctl_wdata(bus_wdata[7:0]),
      .clr      (clr_vec[g]),
      .ctl_q    (ctl[g]),
      .stat_q   (stat[g]),
      .req_norm (req_n[g]),
      .req_fast (req_f[g])
    );
  end

  intc_pick #(.N(NUM_SRC)) u_pick_n (
    .clk(clk), .rst(rst), .req(req_n), .rotate(rot_n), .last(last_n),
    .any(any_n), .win(win_n));
  intc_pick #(.N(NUM_SRC)) u_pick_f (
    .clk(clk), .rst(rst), .req(req_f), .rotate(rot_f), .last(last_f),
    .any(any_f), .win(win_f));

  assign ack_n = any_n && clr_vec[win_n];
  assign ack_f = any_f && clr_vec[win_f];

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_n  <= 1'b0;
      rot_f  <= 1'b0;
      last_n <= '1;
      last_f <= '1;
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == ADR_PRI_NORM) rot_n <= bus_wdata[PRI_ROT_BIT];
      if (bus_wr && bus_addr == ADR_PRI_FAST) rot_f <= bus_wdata[PRI_ROT_BIT];
      if (ack_n) last_n <= win_n;
      if (ack_f) last_f <= win_f;
      irq_o <= any_n;
      fiq_o <= any_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      bus_rdata <= '0;
      if (bus_addr == ADR_PRI_NORM)
        bus_rdata <= 32'({rot_n, 6'(win_n)});
      else if (bus_addr == ADR_PRI_FAST)
        bus_rdata <= 32'({rot_f, 6'(win_f)});
      else if (ctl_sel)
        bus_rdata <= {24'd0, ctl[bus_addr[5:0]]};
      else
        for (int w = 0; w < NWORD; w++)
          if (bus_addr == ADR_STAT_LO + 8'(4 * w)) bus_rdata <= stat[w*32 +: 32];
    end
  end

  p_rst_quiet_r1: assert property (@(posedge clk) $past(rst) |-> (!irq_o && !fiq_o));
  p_ack_ptr_r9: assert property (@(posedge clk) disable iff (rst)
    ack_n |=> (last_n == $past(win_n)));
  p_norm_out_r7: assert property (@(posedge clk) disable iff (rst)
    (req_n == '0) |=> !irq_o);
  p_fast_out_r7: assert property (@(posedge clk) disable iff (rst)
    (req_f == '0) |=> !fiq_o);
endmodule

// File: tb/tb_intc_rotpri.sv
`timescale 1ns/1ps
module tb_intc_rotpri;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_in = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  intc_rotpri dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 fiq", 32'(fiq_o), 0);
    rd(8'h20, d); chk("R1 pri norm", d, 32'h3F);
    rd(8'h24, d); chk("R1 pri fast", d, 32'h3F);
    rd(8'h80, d); chk("R1 stat lo", d, 0);
    rd(8'h84, d); chk("R1 stat hi", d, 0);
    rd(8'h45, d); chk("R1 ctl", d, 0);
  endtask

  task automatic t_ctl();
    logic [31:0] d;
    wr(8'h45, 32'h6B); rd(8'h45, d); chk("R2 readback", d, 32'h6B);
    wr(8'h45, 32'h00); rd(8'h45, d); chk("R2 cleared", d, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(8'h40 + 8'd10, 32'h08);
    src_in[10] = 1'b1; settle();
    rd(8'h80, d); chk("R3 level high", d, 32'h400);
    chk("R7 irq level", 32'(irq_o), 1);
    rd(8'h20, d); chk("R8 pri 10", d, 32'd10);
    wr(8'h80, 32'h400); settle();
    rd(8'h80, d); chk("R3 w1c ignored", d, 32'h400);
    src_in[10] = 1'b0; settle();
    rd(8'h80, d); chk("R3 level low", d, 0);
    chk("R7 irq off", 32'(irq_o), 0);
    src_in[10] = 1'b1; wr(8'h40 + 8'd10, 32'h00); settle();
    rd(8'h80, d); chk("R3 disabled zero", d, 0);
    src_in[10] = 1'b0; settle();
  endtask

  task automatic t_rise();
    logic [31:0] d;
    wr(8'h40 + 8'd40, 32'h28);
    src_in[40] = 1'b1; settle(); src_in[40] = 1'b0; settle();
    rd(8'h84, d); chk("R4 rise latched", d, 32'h100);
    chk("R4 irq", 32'(irq_o), 1);
    rd(8'h20, d); chk("R8 pri 40", d, 32'd40);
    wr(8'h84, 32'h100); settle();
    rd(8'h84, d); chk("R4 cleared", d, 0);
    chk("R4 irq off", 32'(irq_o), 0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    wr(8'h40 + 8'd33, 32'h48);
    src_in[33] = 1'b1; settle();
    rd(8'h84, d); chk("R5 rise ignored", d, 0);
    src_in[33] = 1'b0; settle();
    rd(8'h84, d); chk("R5 fall latched", d, 32'h2);
    wr(8'h84, 32'h2); wr(8'h40 + 8'd33, 32'h00); settle();
    rd(8'h84, d); chk("R5 cleared", d, 0);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    src_in[40] = 1'b1; settle(); src_in[40] = 1'b0; settle();
    wr(8'h40 + 8'd40, 32'h20); settle();
    chk("R6 irq hidden", 32'(irq_o), 0);
    rd(8'h84, d); chk("R6 status kept", d, 32'h100);
    rd(8'h20, d); chk("R6 pri idle", d, 32'h3F);
    wr(8'h40 + 8'd40, 32'h28); settle();
    chk("R6 irq back", 32'(irq_o), 1);
    wr(8'h84, 32'h100); wr(8'h40 + 8'd40, 32'h00); settle();
  endtask

  task automatic t_route();
    logic [31:0] d;
    wr(8'h40 + 8'd20, 32'h09);
    wr(8'h40 + 8'd21, 32'h0B);
    src_in[21] = 1'b1; settle();
    chk("R7 other route irq", 32'(irq_o), 0);
    chk("R7 other route fiq", 32'(fiq_o), 0);
    rd(8'h80, d); chk("R7 other route status", d, 32'h200000);
    src_in[20] = 1'b1; settle();
    chk("R7 fiq on", 32'(fiq_o), 1);
    chk("R7 irq stays off", 32'(irq_o), 0);
    rd(8'h24, d); chk("R8 fast pri 20", d, 32'd20);
    rd(8'h20, d); chk("R8 norm pri idle", d, 32'h3F);
    src_in[21:20] = 2'b00; wr(8'h54, 0); wr(8'h55, 0); settle();
    chk("R7 fiq off", 32'(fiq_o), 0);
  endtask

  task automatic t_src63();
    logic [31:0] d;
    rd(8'h84, d); chk("R8 idle bit31", d & 32'h8000_0000, 0);
    wr(8'h40 + 8'd63, 32'h08); src_in[63] = 1'b1; settle();
    rd(8'h20, d); chk("R8 pri 63", d, 32'd63);
    rd(8'h84, d); chk("R8 real bit31", d, 32'h8000_0000);
    src_in[63] = 1'b0; wr(8'h7F, 0); settle();
  endtask

  task automatic t_rotate();
    logic [31:0] d;
    wr(8'h43, 32'h08); wr(8'h47, 32'h08); wr(8'h4C, 32'h08);
    src_in[3] = 1'b1; src_in[7] = 1'b1; src_in[12] = 1'b1; settle();
    rd(8'h20, d); chk("R8 fixed lowest", d, 32'd3);
    wr(8'h80, 32'h8);
    rd(8'h20, d); chk("R9 fixed ignores pointer", d, 32'd3);
    wr(8'h20, 32'h40);
    rd(8'h20, d); chk("R9 after 3", d, 32'h40 | 32'd7);
    wr(8'h80, 32'h80);
    rd(8'h20, d); chk("R9 after 7", d, 32'h40 | 32'd12);
    wr(8'h80, 32'h1000);
    rd(8'h20, d); chk("R9 wrap", d, 32'h40 | 32'd3);
    wr(8'h20, 32'h0);
    rd(8'h20, d); chk("R9 back to fixed", d, 32'd3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctl();
    t_level();
    t_rise();
    t_fall();
    t_disable();
    t_route();
    t_src63();
    t_rotate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule